// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address seen on the PCI bus into a 34-bit host memory address for DMA. Software programs a set of translation windows through a 64-bit register port. Each window has three registers: a base, a size mask and a translated base. When a translation request arrives, every window compares the bus address against its base over the bits that its size mask leaves significant. The lowest-numbered enabled window that matches decides the result.

A window works in one of two modes. In direct mode it relocates the address: the bits above the window size come from the translated base, and the bits below it are kept from the bus address. In scatter-gather mode it forms the address of a 64-bit page-table entry and issues one read on a simple memory request/response port. While that read is outstanding the block reports busy. When the entry returns, the block builds the final page address from the entry and the bus-address page offset. When no enabled window matches, the request completes at once with a miss flag and no memory read is made.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset every window register reads zero, and `rsp_valid`, `rsp_hit`, `rsp_miss`, `busy`, `mem_req` and `reg_rdata` are all low.
- R2: The register index is `reg_off >> 6`. Window w uses index 4w for its base, 4w+1 for its mask and 4w+2 for its translated base; index 4w+3 reads zero. A 64-bit write (`reg_wide`=1) updates the addressed register. A 64-bit read returns the value on `reg_rdata` one cycle after the read strobe; in every other cycle `reg_rdata` is zero.
- R3: An access with `reg_wide`=0 changes no register, and a read made that way returns zero.
- R4: Index 16, the scatter-gather invalidate register, accepts writes with no effect on any register and reads zero. Every other index at or above 16 also reads zero.
- R5: Window w matches when (bus address AND C) equals (base AND C), where C is the inverse of the mask ANDed with bits 30:20.
- R6: Base bit 0 enables a window and base bit 1 selects scatter-gather. A disabled window is skipped even if it matches. Among enabled matching windows, the lowest index is used.
- R7: In direct mode, with M = (mask AND bits 30:20) OR 0xFFFFF, the result is (translated base AND NOT M) OR (bus address AND M). It is given with `rsp_valid` and `rsp_hit` in the cycle after the request.
- R8: When no enabled window matches, `rsp_valid` and `rsp_miss` are high in the cycle after the request and `mem_req` stays low. `rsp_hit` and `rsp_miss` are low whenever `rsp_valid` is low, and exactly one of them is high when it is high.
- R9: In scatter-gather mode, `mem_req` pulses for one cycle in the cycle after the request. `mem_addr` is (translated base AND NOT(((mask AND bits 30:20) >> 10) OR 0x3FF)) OR ((bus address AND ((mask AND bits 30:20) OR bits 19:13)) >> 10).
- R10: One cycle after `mem_rsp_valid` arrives during a fetch, `rsp_valid` and `rsp_hit` are high, with the address ((entry AND NOT 1) << 12) OR bus address bits 12:0. A response that arrives while no fetch is outstanding is ignored.
- R11: `busy` is high from the cycle of `mem_req` up to and including the cycle in which the response is taken, and is low when the result is given. Translation requests that arrive while `busy` is high are dropped.
- R12: Every translated address is cut to its low 34 bits, so translated-base bits above 33 never appear on `rsp_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wide | input | 1 | Access is a full 64-bit access |
| reg_off | input | 12 | Byte offset from the block base |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the read strobe |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | PCI bus address to translate |
| rsp_valid | output | 1 | Translation result is present |
| rsp_hit | output | 1 | Result came from a window |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_addr | output | 34 | Translated host address |
| busy | output | 1 | Page-table read outstanding |
| mem_req | output | 1 | Page-table read request pulse |
| mem_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read data is present |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
Direct hits and misses must show on `rsp_valid` exactly one rising edge after the request is sampled. A scatter-gather request must raise `mem_req` and `busy` after one edge, and its final result must appear one edge after the table response. Register read data is due one edge after the read strobe. The bench's reference model advances on each rising edge from the inputs sampled there, and the outputs are compared with it on the following falling edge, so every result is checked in the one cycle in which it is due, and an early or late result counts as a failure.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

    localparam int REG_W        = 64;
    localparam int REGS_PER_WIN = 4;
    localparam int SLOT_BASE    = 0;
    localparam int SLOT_MASK    = 1;
    localparam int SLOT_XLT     = 2;
    localparam int OFF_SHIFT    = 6;

    localparam int EN_BIT       = 0;
    localparam int SG_BIT       = 1;
    localparam int SG_SHIFT     = 10;
    localparam int PAGE_SHIFT   = 12;
    localparam int PAGE_OFF_W   = 13;

    // bits 30:20 of a mask register select the window size
    localparam logic [REG_W-1:0] SIZE_FIELD = 64'h0000_0000_7FF0_0000;
    localparam logic [REG_W-1:0] DIRECT_LOW = 64'h0000_0000_000F_FFFF;
    localparam logic [REG_W-1:0] TABLE_LOW  = 64'h0000_0000_0000_03FF;
    localparam logic [REG_W-1:0] PAGE_IDX   = 64'h0000_0000_000F_E000;

    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [0:0] {
        XL_IDLE  = 1'b0,
        XL_FETCH = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic  hit;
        logic  sg;
        word_t direct_addr;
        word_t pte_addr;
    } win_res_t;

endpackage

// File: rtl/dwx_regfile.sv
module dwx_regfile
    import dwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int OFF_W   = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic                           reg_wide,
    input  logic [OFF_W-1:0]               reg_off,
    input  logic [REG_W-1:0]               reg_wdata,
    output logic [REG_W-1:0]               reg_rdata,
    output logic [NUM_WIN-1:0][REG_W-1:0]  win_base,
    output logic [NUM_WIN-1:0][REG_W-1:0]  win_mask,
    output logic [NUM_WIN-1:0][REG_W-1:0]  win_xlt
);

    localparam int IDX_W = OFF_W - OFF_SHIFT;

    typedef struct packed {
        logic [NUM_WIN-1:0][REG_W-1:0] base;
        logic [NUM_WIN-1:0][REG_W-1:0] mask;
        logic [NUM_WIN-1:0][REG_W-1:0] xlt;
        logic [REG_W-1:0]              rdata;
    } rf_t;

    rf_t d, q;
    logic [IDX_W-1:0] idx;

    assign idx = IDX_W'(reg_off >> OFF_SHIFT);

    always_comb begin
        d       = q;
        d.rdata = '0;
        // reads see the register contents before a same-cycle write
        if (reg_rd && reg_wide) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (int'(idx) == w * REGS_PER_WIN + SLOT_BASE) d.rdata = q.base[w];
                if (int'(idx) == w * REGS_PER_WIN + SLOT_MASK) d.rdata = q.mask[w];
                if (int'(idx) == w * REGS_PER_WIN + SLOT_XLT)  d.rdata = q.xlt[w];
            end
        end
        // invalidate and unmapped indices fall through: no state change
        if (reg_wr && reg_wide) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (int'(idx) == w * REGS_PER_WIN + SLOT_BASE) d.base[w] = reg_wdata;
                if (int'(idx) == w * REGS_PER_WIN + SLOT_MASK) d.mask[w] = reg_wdata;
                if (int'(idx) == w * REGS_PER_WIN + SLOT_XLT)  d.xlt[w]  = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata = q.rdata;
    assign win_base  = q.base;
    assign win_mask  = q.mask;
    assign win_xlt   = q.xlt;

endmodule

// File: rtl/dwx_window.sv
module dwx_window
    import dwx_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] mask,
    input  logic [REG_W-1:0] xlt,
    input  logic [BUS_W-1:0] bus_addr,
    output win_res_t         res
);

    word_t a;
    word_t size_bits;
    word_t cmp;
    word_t off_mask;
    word_t tbl_mask;
    word_t idx_mask;

    always_comb begin
        a         = word_t'(bus_addr);
        size_bits = mask & SIZE_FIELD;
        cmp       = ~mask & SIZE_FIELD;

        res.hit   = base[EN_BIT] && ((a & cmp) == (base & cmp));
        res.sg    = base[SG_BIT];

        // direct relocation: size bits and the low 1 MB come from the bus
        off_mask        = size_bits | DIRECT_LOW;
        res.direct_addr = (xlt & ~off_mask) | (a & off_mask);

        // table walk: page index scaled down to an 8-byte entry offset
        tbl_mask     = ~((size_bits >> SG_SHIFT) | TABLE_LOW);
        idx_mask     = size_bits | PAGE_IDX;
        res.pte_addr = (xlt & tbl_mask) | ((a & idx_mask) >> SG_SHIFT);
    end

endmodule

// File: rtl/dwx_select.sv
module dwx_select #(
    parameter int NUM_WIN = 4,
    parameter int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any_hit,
    output logic [SEL_W-1:0]   sel
);

    always_comb begin
        any_hit = |hits;
        sel     = '0;
        // descending scan so the lowest index is written last
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits[w]) sel = SEL_W'(w);
        end
    end

endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate
    import dwx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BUS_W   = 32,
    parameter int PHYS_W  = 34,
    parameter int OFF_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_wide,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PHYS_W-1:0] rsp_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);

    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0][REG_W-1:0] win_base;
    logic [NUM_WIN-1:0][REG_W-1:0] win_mask;
    logic [NUM_WIN-1:0][REG_W-1:0] win_xlt;
    win_res_t                      res [NUM_WIN];
    logic [NUM_WIN-1:0]            hits;
    logic                          any_hit;
    logic [SEL_W-1:0]              sel;
    win_res_t                      pick;

    dwx_regfile #(
        .NUM_WIN (NUM_WIN),
        .OFF_W   (OFF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wide  (reg_wide),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_xlt   (win_xlt)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dwx_window #(
            .BUS_W (BUS_W)
        ) u_win (
            .base     (win_base[g]),
            .mask     (win_mask[g]),
            .xlt      (win_xlt[g]),
            .bus_addr (req_addr),
            .res      (res[g])
        );
        assign hits[g] = res[g].hit;
    end

    dwx_select #(
        .NUM_WIN (NUM_WIN),
        .SEL_W   (SEL_W)
    ) u_sel (
        .hits    (hits),
        .any_hit (any_hit),
        .sel     (sel)
    );

    assign pick = res[sel];

    typedef struct packed {
        xl_state_e              st;
        logic                   mem_req;
        word_t                  mem_addr;
        logic [PAGE_OFF_W-1:0]  page_off;
        logic                   rsp_valid;
        logic                   rsp_hit;
        logic                   rsp_miss;
        logic [PHYS_W-1:0]      rsp_addr;
    } xl_t;

    xl_t   d, q;
    word_t entry;
    word_t sg_full;

    always_comb begin
        d           = q;
        d.mem_req   = 1'b0;
        d.rsp_valid = 1'b0;
        d.rsp_hit   = 1'b0;
        d.rsp_miss  = 1'b0;
        entry       = mem_rsp_data & ~word_t'(1);
        sg_full     = (entry << PAGE_SHIFT) | word_t'(q.page_off);
        case (q.st)
            XL_IDLE: begin
                if (req_valid) begin
                    if (!any_hit) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_miss  = 1'b1;
                        d.rsp_addr  = '0;
                    end else if (pick.sg) begin
                        d.mem_req  = 1'b1;
                        d.mem_addr = pick.pte_addr;
                        d.page_off = req_addr[PAGE_OFF_W-1:0];
                        d.st       = XL_FETCH;
                    end else begin
                        d.rsp_valid = 1'b1;
                        d.rsp_hit   = 1'b1;
                        d.rsp_addr  = pick.direct_addr[PHYS_W-1:0];
                    end
                end
            end
            XL_FETCH: begin
                if (mem_rsp_valid) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_hit   = 1'b1;
                    d.rsp_addr  = sg_full[PHYS_W-1:0];
                    d.st        = XL_IDLE;
                end
            end
            default: d.st = XL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_hit   = q.rsp_hit;
    assign rsp_miss  = q.rsp_miss;
    assign rsp_addr  = q.rsp_addr;
    assign busy      = (q.st == XL_FETCH);
    assign mem_req   = q.mem_req;
    assign mem_addr  = q.mem_addr;

endmodule

// File: rtl/dwx_checker.sv
module dwx_checker (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_rsp_valid,
    input logic busy,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss
);

    AST_ONE_RESULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R8

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss)); // R8

    AST_MISS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !mem_req); // R8

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R9

    AST_BUSY_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11

    AST_RESULT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy); // R11

    AST_FETCH_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rsp_valid) |=> (rsp_valid && rsp_hit)); // R10

endmodule

bind dma_win_xlate dwx_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss)
);

// File: tb/dma_win_xlate_test.sv
module dma_win_xlate_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, reg_wide;
    logic [11:0] reg_off;
    logic [63:0] reg_wdata, reg_rdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid, rsp_hit, rsp_miss, busy, mem_req;
    logic [33:0] rsp_addr;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #2.5 clk = ~clk;

    dma_win_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wide(reg_wide),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_addr(rsp_addr), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string tag    = "R1";

    // reference model state
    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_xlt  [4];
    bit          m_busy;
    logic [63:0] m_lo;
    bit          e_rv, e_hit, e_miss, e_mreq, e_busy;
    logic [33:0] e_addr;
    logic [63:0] e_maddr, e_rd;
    logic [63:0] t_a, t_cmp, t_sz, t_off, t_full, t_nrd;
    int          t_win;

    function automatic logic [63:0] mdl_read(int idx);
        if (idx >= 16) return 64'h0;
        case (idx % 4)
            0: return m_base[idx / 4];
            1: return m_mask[idx / 4];
            2: return m_xlt[idx / 4];
            default: return 64'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 0; m_mask[i] = 0; m_xlt[i] = 0;
            end
            m_busy = 0; m_lo = 0;
            e_rv = 0; e_hit = 0; e_miss = 0; e_mreq = 0; e_busy = 0;
            e_addr = 0; e_maddr = 0; e_rd = 0;
        end else begin
            t_nrd = 64'h0;
            if (reg_rd && reg_wide) t_nrd = mdl_read(int'(reg_off) / 64);
            e_rv = 0; e_hit = 0; e_miss = 0; e_mreq = 0;
            if (m_busy) begin
                if (mem_rsp_valid) begin
                    t_full = ((mem_rsp_data & ~64'h1) << 12) | m_lo;
                    e_rv = 1; e_hit = 1; e_addr = t_full[33:0];
                    m_busy = 0;
                end
            end else if (req_valid) begin
                t_a   = {32'h0, req_addr};
                t_win = -1;
                for (int i = 0; i < 4; i++) begin
                    t_cmp = ~m_mask[i] & 64'h7FF0_0000;
                    if (t_win < 0 && m_base[i][0] &&
                        ((t_a & t_cmp) == (m_base[i] & t_cmp))) t_win = i;
                end
                if (t_win < 0) begin
                    e_rv = 1; e_miss = 1; e_addr = 0;
                end else begin
                    t_sz = m_mask[t_win] & 64'h7FF0_0000;
                    if (m_base[t_win][1]) begin
                        e_mreq  = 1;
                        e_maddr = (m_xlt[t_win] & ~((t_sz >> 10) | 64'h3FF)) |
                                  ((t_a & (t_sz | 64'hF_E000)) >> 10);
                        m_lo    = t_a & 64'h1FFF;
                        m_busy  = 1;
                    end else begin
                        t_off  = t_sz | 64'hF_FFFF;
                        t_full = (m_xlt[t_win] & ~t_off) | (t_a & t_off);
                        e_rv = 1; e_hit = 1; e_addr = t_full[33:0];
                    end
                end
            end
            if (reg_wr && reg_wide && (int'(reg_off) / 64) < 16) begin
                case ((int'(reg_off) / 64) % 4)
                    0: m_base[(int'(reg_off) / 64) / 4] = reg_wdata;
                    1: m_mask[(int'(reg_off) / 64) / 4] = reg_wdata;
                    2: m_xlt[(int'(reg_off) / 64) / 4]  = reg_wdata;
                    default: ;
                endcase
            end
            e_rd   = t_nrd;
            e_busy = m_busy;
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk("rsp_hit",   64'(rsp_hit),   64'(e_hit));
        chk("rsp_miss",  64'(rsp_miss),  64'(e_miss));
        chk("busy",      64'(busy),      64'(e_busy));
        chk("mem_req",   64'(mem_req),   64'(e_mreq));
        chk("reg_rdata", reg_rdata,      e_rd);
        if (e_rv)   chk("rsp_addr", 64'(rsp_addr), 64'(e_addr));
        if (e_mreq) chk("mem_addr", mem_addr, e_maddr);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int idx, logic [63:0] data, bit wide);
        reg_wr = 1; reg_wide = wide; reg_off = 12'(idx * 64); reg_wdata = data;
        @(negedge clk);
        reg_wr = 0; reg_wide = 0;
    endtask

    task automatic rd(int idx, bit wide);
        reg_rd = 1; reg_wide = wide; reg_off = 12'(idx * 64);
        @(negedge clk);
        reg_rd = 0; reg_wide = 0;
    endtask

    task automatic xlate(logic [31:0] a);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic respond(logic [63:0] e);
        mem_rsp_valid = 1; mem_rsp_data = e;
        @(negedge clk);
        mem_rsp_valid = 0;
    endtask

    initial begin
        rst_n = 0; reg_wr = 0; reg_rd = 0; reg_wide = 0; reg_off = 0;
        reg_wdata = 0; req_valid = 0; req_addr = 0;
        mem_rsp_valid = 0; mem_rsp_data = 0;
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(1);
        rd(0, 1); rd(5, 1); idle(1);

        tag = "R2";
        wr(8, 64'h1111_2222_3333_4444, 1);
        wr(9, 64'h0000_0000_0070_0000, 1);
        wr(10, 64'hDEAD_BEEF_0000_1000, 1);
        rd(8, 1); rd(9, 1); rd(10, 1); rd(11, 1);
        wr(8, 64'hA5A5_0000_0000_0000, 1); rd(8, 1); idle(1);

        tag = "R3";
        wr(9, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        rd(9, 1); rd(9, 0); rd(8, 0); idle(1);

        tag = "R4";
        wr(16, 64'h1234_5678_9ABC_DEF0, 1);
        rd(16, 1); rd(8, 1); rd(9, 1); rd(10, 1); rd(40, 1); idle(1);
        wr(8, 64'h0, 1); wr(9, 64'h0, 1); wr(10, 64'h0, 1);

        tag = "R7";
        wr(0, 64'h0000_0000_4000_0001, 1);
        wr(1, 64'h0000_0000_0030_0000, 1);
        wr(2, 64'hABCD_0001_2340_0000, 1);
        xlate(32'h4012_3456); idle(1);
        tag = "R12";
        xlate(32'h403F_FFFF); idle(1);

        tag = "R5";
        xlate(32'h4040_0000); xlate(32'hC000_0000); xlate(32'h4000_0000); idle(1);

        tag = "R8";
        xlate(32'h1000_0000); idle(2);

        tag = "R6";
        wr(4, 64'h0000_0000_5000_0000, 1);
        wr(6, 64'h0000_0000_0111_0000, 1);
        wr(8, 64'h0000_0000_5000_0001, 1);
        wr(10, 64'h0000_0002_2220_0000, 1);
        xlate(32'h5001_2345); idle(1);
        wr(4, 64'h0000_0000_5000_0001, 1);
        xlate(32'h5001_2345);
        xlate(32'h5009_8765); idle(1);

        tag = "R9";
        wr(12, 64'h0000_0000_8000_0003, 1);
        wr(13, 64'h0000_0000_0010_0000, 1);
        wr(14, 64'hF000_0000_0123_4000, 1);
        xlate(32'h8015_6789);
        tag = "R11";
        idle(2);
        xlate(32'h4000_0010); idle(1);
        tag = "R10";
        respond(64'h0000_0000_00AB_CDE1); idle(2);
        respond(64'h0000_0000_0000_7777); idle(1);

        tag = "R9";
        wr(13, 64'h0, 1);
        xlate(32'h800F_E123);
        tag = "R10";
        respond(64'hFFFF_FFFF_FFFF_FFFF);
        xlate(32'h4000_0abc); idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule